// File: doc/BRIEF.md
# Periodic Reload Interrupt Timer

This block is a 32-bit down-counter with a word-addressed register port and one level-sensitive interrupt line. The counter decrements once per cycle in which a tick enable is high. Software sets a reload value and turns the timer on. Each time the count expires, a pending flag is raised and the counter restarts from the reload value. The result is a steady periodic interrupt, which software acknowledges by writing the status word.

Register access uses a single write strobe and a combinational read port. Five word offsets are decoded: control (0), status (1), load (2), compare (3) and a read-only counter (4). The compare word is storage only. A reset bit in the control word returns the timer to a stopped, zero-reload state without touching the system reset.

Top module: `periodic_reload_timer`

## Requirements
- R1: Decoded word offsets are control=0, status=1, load=2, compare=3 and counter=4. Reads of any other offset return zero, and writes to them change no register.
- R2: Control bit 0 is the enable and reads back as written. All other control bits read as zero.
- R3: Status bit 0 reads the pending level and the other status bits read zero. A write to status with any data clears the pending level.
- R4: irq_o is high exactly when the pending level is set and the enable bit is set.
- R5: Writing the load word stores the reload value and loads the counter with it. Both read back the new value on the next cycle.
- R6: While enabled, the counter drops by one on each cycle with tick_i high. When disabled, or when tick_i is low, the counter holds its value.
- R7: A tick while enabled and at count zero is an expiry. It sets the pending level and reloads the counter from the load word, so the period is load+1 ticks. A load value of zero expires on every tick.
- R8: A control write with bit 16 set clears the enable and the load word. The counter stops and keeps its current value, and bit 16 is never stored.
- R9: The compare word reads back what was written and has no effect on the count or the interrupt.
- R10: If an expiry and a status write fall in the same cycle, the pending level stays set.
- R11: If a load write and an enabled tick fall in the same cycle, the counter takes the written value and does not decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Word offset |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
The count is exercised in three ways: ticks while disabled, which must leave it unchanged; runs of ticks while enabled, which step it down and wrap it at zero; and a zero reload, which must expire on every tick. Acknowledge writes are tried with arbitrary data, both apart from an expiry and in the same cycle as one. This separates a clear that is decoded by its data, or one that beats the expiry, from the intended behaviour. Disabling the timer while the pending level is still set shows that the enable gates the output and that the flag itself is kept. A software reset taken mid-count shows that the reset stops the counter without zeroing it.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam int OFF_CTRL = 0;
  localparam int OFF_STAT = 1;
  localparam int OFF_LOAD = 2;
  localparam int OFF_CMP  = 3;
  localparam int OFF_CNT  = 4;
  localparam int EN_BIT   = 0;
  localparam int SWR_BIT  = 16;
endpackage

// File: rtl/prt_ctrl_regs.sv
module prt_ctrl_regs
  import prt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              expire_i,
  output logic              en_o,
  output logic              pend_o,
  output logic              load_we_o,
  output logic [DATA_W-1:0] load_o,
  output logic [DATA_W-1:0] cmp_o
);
  logic ctrl_we, stat_we, cmp_we, swr;
  logic en_q, pend_q;
  logic [DATA_W-1:0] load_q, cmp_q;

  assign ctrl_we   = wr_en_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign stat_we   = wr_en_i && (addr_i == ADDR_W'(OFF_STAT));
  assign load_we_o = wr_en_i && (addr_i == ADDR_W'(OFF_LOAD));
  assign cmp_we    = wr_en_i && (addr_i == ADDR_W'(OFF_CMP));
  assign swr       = ctrl_we && wr_data_i[SWR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      load_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (swr) begin
        en_q   <= 1'b0;
        load_q <= '0;
      end else begin
        if (ctrl_we)   en_q   <= wr_data_i[EN_BIT];
        if (load_we_o) load_q <= wr_data_i;
      end
      if (cmp_we) cmp_q <= wr_data_i;
    end
  end

  // expiry has priority over acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (expire_i) pend_q <= 1'b1;
    else if (stat_we)  pend_q <= 1'b0;
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign load_o = load_q;
  assign cmp_o  = cmp_q;

  AST_SWR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFF_CTRL) && wr_data_i[SWR_BIT]) |=> (!en_o && load_o == '0)); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFF_STAT) && !expire_i) |=> !pend_o); // R3
  AST_EXPIRY_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> pend_o); // R10
endmodule

// File: rtl/prt_down_counter.sv
module prt_down_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              load_we_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic [DATA_W-1:0] reload_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              expire_o
);
  logic [DATA_W-1:0] cnt_q;
  logic step;

  assign step     = en_i && tick_i && !load_we_i;
  assign expire_o = step && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (load_we_i) cnt_q <= load_data_i;
    else if (expire_o)  cnt_q <= reload_i;
    else if (step)      cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_LOAD_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we_i |=> cnt_o == $past(load_data_i)); // R5 R11
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_we_i && !(en_i && tick_i)) |=> $stable(cnt_o)); // R6
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> cnt_o == $past(reload_i)); // R7
endmodule

// File: rtl/periodic_reload_timer.sv
module periodic_reload_timer
  import prt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic en, pend, load_we, expire;
  logic [DATA_W-1:0] load_val, cmp_val, cnt_val;

  prt_ctrl_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .expire_i  (expire),
    .en_o      (en),
    .pend_o    (pend),
    .load_we_o (load_we),
    .load_o    (load_val),
    .cmp_o     (cmp_val)
  );

  prt_down_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .tick_i      (tick_i),
    .load_we_i   (load_we),
    .load_data_i (wr_data_i),
    .reload_i    (load_val),
    .cnt_o       (cnt_val),
    .expire_o    (expire)
  );

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      ADDR_W'(OFF_CTRL): rd_data_o[EN_BIT] = en;
      ADDR_W'(OFF_STAT): rd_data_o[0]      = pend;
      ADDR_W'(OFF_LOAD): rd_data_o         = load_val;
      ADDR_W'(OFF_CMP):  rd_data_o         = cmp_val;
      ADDR_W'(OFF_CNT):  rd_data_o         = cnt_val;
      default:           rd_data_o         = '0;
    endcase
  end

  assign irq_o = pend && en;

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend && en)); // R4
  AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && en) |-> irq_o); // R4
endmodule

// File: tb/periodic_reload_timer_bench.sv
`timescale 1ns/1ps
module periodic_reload_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  periodic_reload_timer u_periodic_reload_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq)
  );

  // {op[1:0], req[3:0], addr[2:0], tick, data[31:0], exp[31:0]}
  // op: 0 write, 1 read check, 2 run data ticks, 3 irq check
  localparam int N = 53;
  localparam logic [73:0] TABLE [0:N-1] = '{
    {2'd0,4'd5,3'd2,1'b0,32'd5,32'd0},            // R5 load 5
    {2'd1,4'd5,3'd4,1'b0,32'd0,32'd5},            // R5 counter
    {2'd1,4'd5,3'd2,1'b0,32'd0,32'd5},            // R5 load
    {2'd2,4'd6,3'd0,1'b0,32'd3,32'd0},            // R6 ticks while off
    {2'd1,4'd6,3'd4,1'b0,32'd0,32'd5},            // R6 held
    {2'd0,4'd2,3'd0,1'b0,32'h0000FF01,32'd0},     // R2 enable
    {2'd1,4'd2,3'd0,1'b0,32'd0,32'd1},            // R2 readback
    {2'd2,4'd6,3'd0,1'b0,32'd2,32'd0},            // R6
    {2'd1,4'd6,3'd4,1'b0,32'd0,32'd3},
    {2'd2,4'd6,3'd0,1'b0,32'd3,32'd0},
    {2'd1,4'd6,3'd4,1'b0,32'd0,32'd0},
    {2'd1,4'd3,3'd1,1'b0,32'd0,32'd0},            // R3 not yet
    {2'd2,4'd7,3'd0,1'b0,32'd1,32'd0},            // R7 expiry
    {2'd1,4'd7,3'd4,1'b0,32'd0,32'd5},
    {2'd1,4'd3,3'd1,1'b0,32'd0,32'd1},
    {2'd3,4'd4,3'd0,1'b0,32'd0,32'd1},            // R4
    {2'd0,4'd3,3'd1,1'b0,32'hDEADBEEF,32'd0},     // R3 ack any data
    {2'd1,4'd3,3'd1,1'b0,32'd0,32'd0},
    {2'd3,4'd4,3'd0,1'b0,32'd0,32'd0},
    {2'd2,4'd7,3'd0,1'b0,32'd6,32'd0},            // R7 period load+1
    {2'd1,4'd7,3'd1,1'b0,32'd0,32'd1},
    {2'd1,4'd7,3'd4,1'b0,32'd0,32'd5},
    {2'd0,4'd4,3'd0,1'b0,32'd0,32'd0},            // R4 disable
    {2'd3,4'd4,3'd0,1'b0,32'd0,32'd0},
    {2'd1,4'd3,3'd1,1'b0,32'd0,32'd1},
    {2'd2,4'd6,3'd0,1'b0,32'd4,32'd0},            // R6
    {2'd1,4'd6,3'd4,1'b0,32'd0,32'd5},
    {2'd0,4'd9,3'd3,1'b0,32'h1234,32'd0},         // R9
    {2'd1,4'd9,3'd3,1'b0,32'd0,32'h1234},
    {2'd1,4'd9,3'd4,1'b0,32'd0,32'd5},
    {2'd0,4'd1,3'd5,1'b0,32'hFFFF,32'd0},         // R1 unmapped
    {2'd1,4'd1,3'd5,1'b0,32'd0,32'd0},
    {2'd1,4'd1,3'd7,1'b0,32'd0,32'd0},
    {2'd1,4'd1,3'd2,1'b0,32'd0,32'd5},
    {2'd0,4'd3,3'd1,1'b0,32'd0,32'd0},
    {2'd0,4'd7,3'd0,1'b0,32'd1,32'd0},
    {2'd0,4'd7,3'd2,1'b0,32'd0,32'd0},            // R7 load zero
    {2'd1,4'd5,3'd4,1'b0,32'd0,32'd0},
    {2'd2,4'd7,3'd0,1'b0,32'd1,32'd0},
    {2'd1,4'd7,3'd1,1'b0,32'd0,32'd1},
    {2'd0,4'd3,3'd1,1'b0,32'd0,32'd0},
    {2'd1,4'd3,3'd1,1'b0,32'd0,32'd0},
    {2'd2,4'd7,3'd0,1'b0,32'd1,32'd0},
    {2'd1,4'd7,3'd1,1'b0,32'd0,32'd1},
    {2'd0,4'd7,3'd2,1'b0,32'd9,32'd0},
    {2'd2,4'd6,3'd0,1'b0,32'd2,32'd0},
    {2'd1,4'd6,3'd4,1'b0,32'd0,32'd7},
    {2'd0,4'd8,3'd0,1'b0,32'h00010001,32'd0},     // R8 soft reset
    {2'd1,4'd8,3'd0,1'b0,32'd0,32'd0},
    {2'd1,4'd8,3'd2,1'b0,32'd0,32'd0},
    {2'd2,4'd8,3'd0,1'b0,32'd2,32'd0},
    {2'd1,4'd8,3'd4,1'b0,32'd0,32'd7},
    {2'd3,4'd8,3'd0,1'b0,32'd0,32'd0}
  };

  task automatic cyc(input logic we, input logic [2:0] a, input logic [31:0] d, input logic t);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; tick = t;
    @(posedge clk);
    #1;
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic chk_rd(input int req, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    tests++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL R%0d addr %0d: got %h expected %h", req, a, rdata, exp);
    end
  endtask

  task automatic chk_irq(input int req, input logic exp);
    @(negedge clk);
    #1;
    tests++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL R%0d irq: got %b expected %b", req, irq, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    for (int i = 0; i < 5; i++) chk_rd(1, 3'(i), 32'd0); // R1 R2 R3 zero after reset
    chk_irq(4, 1'b0); // R4

    for (int i = 0; i < N; i++) begin
      logic [1:0]  op;
      logic [3:0]  rq;
      logic [2:0]  a;
      logic        t;
      logic [31:0] d, e;
      {op, rq, a, t, d, e} = TABLE[i];
      case (op)
        2'd0: cyc(1'b1, a, d, t);
        2'd1: chk_rd(int'(rq), a, e);
        2'd2: for (int k = 0; k < int'(d); k++) cyc(1'b0, 3'd0, 32'd0, 1'b1);
        default: chk_irq(int'(rq), e[0]);
      endcase
    end

    // R10: expiry and acknowledge in one cycle
    cyc(1'b1, 3'd0, 32'd1, 1'b0);
    cyc(1'b1, 3'd2, 32'd0, 1'b0);
    cyc(1'b1, 3'd1, 32'd0, 1'b0);
    chk_rd(3, 3'd1, 32'd0);
    cyc(1'b1, 3'd1, 32'hFFFFFFFF, 1'b1);
    chk_rd(10, 3'd1, 32'd1); // R10 pending kept
    chk_irq(10, 1'b1);

    // R11: load write beats same-cycle tick
    cyc(1'b1, 3'd2, 32'd8, 1'b0);
    cyc(1'b0, 3'd0, 32'd0, 1'b1);
    chk_rd(11, 3'd4, 32'd7);
    cyc(1'b1, 3'd2, 32'd8, 1'b1);
    chk_rd(11, 3'd4, 32'd8); // R11 no decrement

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule